// File: doc/BRIEF.md
# Register-Access SPI Master with Power-Up Wake Sequencer

This block lets on-chip logic read and write the 8-bit control and status registers of an external audio receiver over a four-wire serial link. A client raises `req_valid` with a direction flag, a register address and (for writes) a data byte. The block sends the bytes, handles the chip-select framing and the settle gaps around each frame, and then pulses `done`. For a read, the returned byte appears on `rdata` in the same cycle as that pulse. A write is one select frame carrying the device identifier 0x20, the register address and the data. A read is two frames. The first carries 0x20 and the register address, which sets the device's pointer. The second carries the read identifier 0x21 followed by a dummy 0x00, and the byte the device returns during the dummy is captured.

Before it accepts any request, the block brings the device up once. It holds the device reset output low. It then releases it and waits. It then toggles chip select high, low and high, with each level held for the wake interval, which switches the device into its serial-peripheral mode. All intervals are counted in system clocks, derived from the clock-frequency parameter and times given in nanoseconds or microseconds.

The controller states are BOOT, RST_HOLD, POST_RST, WAKE_HI, WAKE_LO, WAKE_END, IDLE, LEAD, LOAD, SHIFT and TRAIL. The transitions are:
- BOOT→RST_HOLD, unconditional.
- RST_HOLD→POST_RST, POST_RST→WAKE_HI, WAKE_HI→WAKE_LO, WAKE_LO→WAKE_END and WAKE_END→IDLE, each on timer expiry.
- IDLE→LEAD on an accepted request.
- LEAD→LOAD on timer expiry.
- LOAD→SHIFT, unconditional.
- SHIFT→LOAD when a byte that is not the last of its frame completes, and SHIFT→TRAIL when the last byte of the frame completes.
- TRAIL→LEAD when a read's first frame is closed, and TRAIL→IDLE when the final frame is closed, which also fires `done`.

Top module: `spiregs_master`

## Requirements
- R1: While `dev_rst_n` is low after reset, `busy` is high, `spi_cs_n` is high and `spi_sclk` is high. `dev_rst_n` stays low for at least RST_US microseconds of clock cycles after `rst_n` is released.
- R2: After `dev_rst_n` rises, chip select stays high for at least the wake interval. It then goes low for exactly the wake interval (WAKE_US × clocks per µs), with no clock edges on `spi_sclk`. It then stays high for at least the wake interval before `busy` first falls.
- R3: The link uses clock polarity and phase mode 3. `spi_sclk` idles high, MOSI changes when `spi_sclk` falls, and MISO is sampled when it rises. Bytes go MSB first. Every low phase of `spi_sclk` lasts CLK_HZ/(2·SCLK_HZ) cycles, and `spi_sclk` is low only while chip select is low.
- R4: A write produces exactly one chip-select-low frame of three bytes: 0x20, then the register address, then the data.
- R5: A read produces two frames: first (0x20, address), then (0x21, 0x00). `rdata` becomes the byte received during the 0x00 byte.
- R6: After chip select falls, at least SETTLE_NS of cycles pass before the first `spi_sclk` fall. After chip select rises, at least that long passes before the next frame or before `done`.
- R7: A request is accepted only in a cycle where `busy` is low. A `req_valid` raised while `busy` is high, including during the wake sequence, starts no frame and leaves `rdata` unchanged.
- R8: `done` is high for exactly one cycle at the end of each transaction, with `busy` low in that cycle. `rdata` changes only in a cycle where `done` is high.
- R9: Bytes received during write frames are discarded: a write leaves `rdata` unchanged.
- R10: A request presented in the cycle where `done` is high is accepted, and `busy` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Data byte for writes |
| busy | output | 1 | High while waking the device or running a transaction |
| done | output | 1 | One-cycle pulse when a transaction ends |
| rdata | output | 8 | Last byte read, updated with `done` |
| dev_rst_n | output | 1 | Active-low reset to the device |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The completion of one transaction and the acceptance of the next can happen in the same cycle. `done` pulses in the first IDLE cycle, and that same cycle is already open to a new request. The bench provokes this by raising `req_valid` for a read on the very clock phase where it first sees `done` at the end of a write. It then judges that `busy` is high on the next cycle and that three frames appear with the expected bytes. It also judges that the read result arrives only with the second `done`, while the first `done` left `rdata` untouched.

// File: rtl/spiregs_pkg.sv
package spiregs_pkg;

    localparam logic [7:0] DEV_ID_WRITE = 8'h20;
    localparam logic [7:0] DEV_ID_READ  = 8'h21;
    localparam logic [7:0] DUMMY_BYTE   = 8'h00;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_RST_HOLD,
        ST_POST_RST,
        ST_WAKE_HI,
        ST_WAKE_LO,
        ST_WAKE_END,
        ST_IDLE,
        ST_LEAD,
        ST_LOAD,
        ST_SHIFT,
        ST_TRAIL
    } ctl_state_t;

    // Byte to send for a given transaction kind, frame and byte slot.
    function automatic logic [7:0] frame_byte(
        input logic       is_wr,
        input logic       second_frame,
        input logic [1:0] slot,
        input logic [7:0] addr,
        input logic [7:0] wdata
    );
        logic [7:0] b;
        if (second_frame) begin
            b = (slot == 2'd0) ? DEV_ID_READ : DUMMY_BYTE;
        end else begin
            unique case (slot)
                2'd0:    b = DEV_ID_WRITE;
                2'd1:    b = addr;
                default: b = is_wr ? wdata : DUMMY_BYTE;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/spiregs_delay.sv
module spiregs_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/spiregs_byte_shifter.sv
module spiregs_byte_shifter #(
    parameter int HALF_C = 25,
    parameter int HW     = $clog2(HALF_C + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       active,
    output logic       fin,
    output logic [7:0] rx
);

    localparam logic [HW-1:0] HALF_LD = HW'(HALF_C - 1);

    logic [7:0]    sh;
    logic [2:0]    bitn;
    logic [HW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            bitn   <= '0;
            cnt    <= '0;
            sclk   <= 1'b1;
            mosi   <= 1'b0;
            active <= 1'b0;
            fin    <= 1'b0;
            rx     <= '0;
        end else begin
            fin <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                sh     <= tx;
                mosi   <= tx[7];
                sclk   <= 1'b0;
                bitn   <= '0;
                cnt    <= HALF_LD;
            end else if (active) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    cnt <= HALF_LD;
                    if (!sclk) begin
                        // rising edge: sample the device
                        sclk <= 1'b1;
                        rx   <= {rx[6:0], miso};
                    end else if (bitn == 3'd7) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        // falling edge: present the next bit
                        sclk <= 1'b0;
                        bitn <= bitn + 1'b1;
                        mosi <= sh[6];
                        sh   <= {sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);                                             // R3
    AST_FIN_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (sclk && !active));                                     // R3

endmodule

// File: rtl/spiregs_master.sv
module spiregs_master #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SCLK_HZ   = 1_000_000,
    parameter int SETTLE_NS = 10_000,
    parameter int WAKE_US   = 1_000,
    parameter int RST_US    = 100_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rdata,
    output logic       dev_rst_n,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    import spiregs_pkg::*;

    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int HALF_RAW   = CLK_HZ / (2 * SCLK_HZ);
    localparam int HALF_C     = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int SET_RAW    = CYC_PER_US * SETTLE_NS / 1000;
    localparam int SETTLE_C   = (SET_RAW < 1) ? 1 : SET_RAW;
    localparam int WAKE_RAW   = CYC_PER_US * WAKE_US;
    localparam int WAKE_C     = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
    localparam int RST_RAW    = CYC_PER_US * RST_US;
    localparam int RST_C      = (RST_RAW < 1) ? 1 : RST_RAW;
    localparam int MAX_AB     = (RST_C > WAKE_C) ? RST_C : WAKE_C;
    localparam int MAX_C      = (MAX_AB > SETTLE_C) ? MAX_AB : SETTLE_C;
    localparam int TW         = $clog2(MAX_C + 1);

    localparam logic [TW-1:0] LD_RST    = TW'(RST_C - 1);
    localparam logic [TW-1:0] LD_WAKE   = TW'(WAKE_C - 1);
    localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_C - 1);

    ctl_state_t state_q, state_d;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;

    logic          eng_start;
    logic          eng_active;
    logic          eng_fin;
    logic [7:0]    eng_rx;
    logic [7:0]    eng_tx;

    logic          wr_q;
    logic [7:0]    addr_q;
    logic [7:0]    wdata_q;
    logic          frame_q;
    logic [1:0]    slot_q;

    logic          last_byte;
    logic          last_frame;
    logic          finish;

    assign last_byte  = wr_q ? (slot_q == 2'd2) : (slot_q == 2'd1);
    assign last_frame = wr_q | frame_q;
    assign finish     = (state_q == ST_TRAIL) && tmr_exp && last_frame;
    assign eng_tx     = frame_byte(wr_q, frame_q, slot_q, addr_q, wdata_q);

    spiregs_delay #(.W(TW)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    spiregs_byte_shifter #(.HALF_C(HALF_C)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .tx     (eng_tx),
        .miso   (spi_miso),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .active (eng_active),
        .fin    (eng_fin),
        .rx     (eng_rx)
    );

    // Next-state and timer/engine control
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        eng_start = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                state_d  = ST_RST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = LD_RST;
            end
            ST_RST_HOLD: if (tmr_exp) begin
                state_d  = ST_POST_RST;
                tmr_load = 1'b1;
                tmr_val  = LD_WAKE;
            end
            ST_POST_RST: if (tmr_exp) begin
                state_d  = ST_WAKE_HI;
                tmr_load = 1'b1;
                tmr_val  = LD_WAKE;
            end
            ST_WAKE_HI: if (tmr_exp) begin
                state_d  = ST_WAKE_LO;
                tmr_load = 1'b1;
                tmr_val  = LD_WAKE;
            end
            ST_WAKE_LO: if (tmr_exp) begin
                state_d  = ST_WAKE_END;
                tmr_load = 1'b1;
                tmr_val  = LD_WAKE;
            end
            ST_WAKE_END: if (tmr_exp) begin
                state_d = ST_IDLE;
            end
            ST_IDLE: if (req_valid) begin
                state_d  = ST_LEAD;
                tmr_load = 1'b1;
                tmr_val  = LD_SETTLE;
            end
            ST_LEAD: if (tmr_exp) begin
                state_d = ST_LOAD;
            end
            ST_LOAD: begin
                eng_start = 1'b1;
                state_d   = ST_SHIFT;
            end
            ST_SHIFT: if (eng_fin) begin
                if (last_byte) begin
                    state_d  = ST_TRAIL;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETTLE;
                end else begin
                    state_d = ST_LOAD;
                end
            end
            ST_TRAIL: if (tmr_exp) begin
                if (last_frame) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d  = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETTLE;
                end
            end
            default: state_d = ST_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Request latch and frame/byte position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            frame_q <= 1'b0;
            slot_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                frame_q <= 1'b0;
                slot_q  <= '0;
            end
            if (state_q == ST_SHIFT && eng_fin) begin
                slot_q <= last_byte ? 2'd0 : slot_q + 1'b1;
            end
            if (state_q == ST_TRAIL && tmr_exp && !last_frame) begin
                frame_q <= 1'b1;
            end
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_cs_n  <= 1'b1;
            dev_rst_n <= 1'b0;
            busy      <= 1'b1;
            done      <= 1'b0;
            rdata     <= '0;
        end else begin
            spi_cs_n  <= !(state_d inside {ST_WAKE_LO, ST_LEAD, ST_LOAD, ST_SHIFT});
            dev_rst_n <= !(state_d inside {ST_BOOT, ST_RST_HOLD});
            busy      <= (state_d != ST_IDLE);
            done      <= finish;
            if (finish && !wr_q) begin
                rdata <= eng_rx;
            end
        end
    end

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rst_n |-> (spi_cs_n && spi_sclk && busy));                 // R1
    AST_SCLK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sclk |-> !spi_cs_n);                                       // R3
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && !spi_cs_n));                  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                // R8
    AST_RDATA_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);                                      // R8
    AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (!spi_cs_n && !eng_active));                      // R6

endmodule

// File: tb/sim_spiregs_master.sv
module sim_spiregs_master;

    localparam int HALF   = 5;
    localparam int SETTLE = 10;
    localparam int WAKE   = 50;
    localparam int RSTC   = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, dev_rst_n, spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b1;
    logic [7:0] rdata;

    always #10 clk = ~clk;

    spiregs_master #(
        .CLK_HZ(50_000_000), .SCLK_HZ(5_000_000), .SETTLE_NS(200),
        .WAKE_US(1), .RST_US(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .dev_rst_n(dev_rst_n), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(negedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Device model: frame logger and read responder
    logic [7:0] log_b [0:7][0:3];
    int         log_n [0:7];
    int         nfr = 0;
    int         bcnt = 0;
    int         bitc = 0;
    logic [7:0] shin = '0;
    logic [7:0] outb = '0;
    logic [7:0] resp = '0;
    int         cs_fall_cyc = 0;
    int         cs_rise_cyc = 0;
    bit         first_fall = 0;
    int         lead_min = 1000000;
    int         trail_min = 1000000;
    int         low_start = 0;
    bit         half_bad = 0;
    int         sclk_falls = 0;

    always @(negedge spi_cs_n) begin
        bcnt = 0;
        bitc = 0;
        first_fall = 0;
        cs_fall_cyc = cyc;
        if (nfr > 0 && (cyc - cs_rise_cyc) < trail_min) trail_min = cyc - cs_rise_cyc;
    end

    always @(posedge spi_cs_n) begin
        if (nfr < 8) log_n[nfr] = bcnt;
        nfr++;
        cs_rise_cyc = cyc;
    end

    always @(negedge spi_sclk) begin
        sclk_falls++;
        if (!spi_cs_n) begin
            if (!first_fall) begin
                first_fall = 1;
                if ((cyc - cs_fall_cyc) < lead_min) lead_min = cyc - cs_fall_cyc;
            end
            low_start = cyc;
            if (bitc == 0)
                outb = (bcnt == 1 && nfr < 8 && log_b[nfr][0] == 8'h21) ? resp : 8'hC3;
            spi_miso = outb[7 - bitc];
        end
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if ((cyc - low_start) != HALF) half_bad = 1;
            shin = {shin[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                if (nfr < 8 && bcnt < 4) log_b[nfr][bcnt] = shin;
                bcnt++;
            end
        end
    end

    task automatic clear_log();
        nfr = 0;
        lead_min = 1000000;
        trail_min = 1000000;
        half_bad = 0;
    endtask

    task automatic issue(input bit wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_frames(input int base, input bit wr, input logic [7:0] a,
                                input logic [7:0] d, input string tag);
        if (wr) begin
            chk(log_n[base] == 3, tag, log_n[base], 3);
            chk(log_b[base][0] == 8'h20, tag, log_b[base][0], 8'h20);
            chk(log_b[base][1] == a, tag, log_b[base][1], a);
            chk(log_b[base][2] == d, tag, log_b[base][2], d);
        end else begin
            chk(log_n[base] == 2 && log_n[base+1] == 2, tag, log_n[base+1], 2);
            chk(log_b[base][0] == 8'h20, tag, log_b[base][0], 8'h20);
            chk(log_b[base][1] == a, tag, log_b[base][1], a);
            chk(log_b[base+1][0] == 8'h21, tag, log_b[base+1][0], 8'h21);
            chk(log_b[base+1][1] == 8'h00, tag, log_b[base+1][1], 8'h00);
        end
    endtask

    // {write, addr, wdata, device response}
    localparam logic [24:0] VEC [7] = '{
        {1'b1, 8'h04, 8'h80, 8'h00},
        {1'b0, 8'h18, 8'h00, 8'h3A},
        {1'b1, 8'h01, 8'h84, 8'h00},
        {1'b0, 8'h0B, 8'h00, 8'h01},
        {1'b1, 8'hFF, 8'h5A, 8'h00},
        {1'b0, 8'h00, 8'h00, 8'hFF},
        {1'b0, 8'h7F, 8'h00, 8'h80}
    };

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        int t0, t_r, t_f, t_u, t_b, n;
        logic p_rst, p_cs, p_busy;
        logic [7:0] prev;

        // Reset state (R1)
        repeat (4) @(negedge clk);
        chk(busy && !dev_rst_n && spi_cs_n && spi_sclk && !done, "R1 reset",
            {busy, dev_rst_n, spi_cs_n, spi_sclk, done}, 5'b10110);
        rst_n = 1'b1;
        t0 = cyc;
        t_r = 0; t_f = 0; t_u = 0; t_b = 0;
        p_rst = dev_rst_n; p_cs = spi_cs_n; p_busy = busy;
        sclk_falls = 0;
        n = 0;
        while (n < 2000 && !(t_b != 0)) begin
            @(negedge clk);
            n++;
            if (n == 20 || n == 180) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h33; req_wdata = 8'h44;
            end else begin
                req_valid = 1'b0;
            end
            if (!p_rst && dev_rst_n) t_r = cyc;
            if (p_cs && !spi_cs_n && t_f == 0) t_f = cyc;
            if (!p_cs && spi_cs_n && t_u == 0) t_u = cyc;
            if (p_busy && !busy) t_b = cyc;
            p_rst = dev_rst_n; p_cs = spi_cs_n; p_busy = busy;
        end
        req_valid = 1'b0;
        chk(t_r - t0 >= RSTC, "R1 reset hold", t_r - t0, RSTC);
        chk(t_f - t_r >= WAKE, "R2 pre-wake high", t_f - t_r, WAKE);
        chk(t_u - t_f == WAKE, "R2 wake low", t_u - t_f, WAKE);
        chk(t_b - t_u >= WAKE, "R2 post-wake high", t_b - t_u, WAKE);
        chk(sclk_falls == 0, "R2 no clock in wake", sclk_falls, 0);

        // Requests during wake were dropped (R7)
        clear_log();
        repeat (100) @(negedge clk);
        chk(nfr == 0 && spi_cs_n && !busy, "R7 wake request ignored", nfr, 0);

        // Vector table
        for (int i = 0; i < 7; i++) begin
            bit wr;
            logic [7:0] a, d, r;
            {wr, a, d, r} = VEC[i];
            resp = r;
            clear_log();
            prev = rdata;
            issue(wr, a, d);
            wait_done();
            chk(done && !busy, "R8 done", {done, busy}, 2'b10);
            chk(cyc - cs_rise_cyc >= SETTLE, "R6 trail before done", cyc - cs_rise_cyc, SETTLE);
            @(negedge clk);
            chk(!done, "R8 single pulse", done, 0);
            chk(nfr == (wr ? 1 : 2), wr ? "R4 frame count" : "R5 frame count", nfr, wr ? 1 : 2);
            check_frames(0, wr, a, d, wr ? "R4 bytes" : "R5 bytes");
            if (wr) chk(rdata == prev, "R9 write keeps rdata", rdata, prev);
            else    chk(rdata == r, "R5 read data", rdata, r);
            chk(lead_min >= SETTLE, "R6 lead", lead_min, SETTLE);
            if (!wr) chk(trail_min >= SETTLE, "R6 gap between frames", trail_min, SETTLE);
            chk(!half_bad, "R3 half period", half_bad, 0);
        end

        // Requests while busy are ignored (R7)
        clear_log();
        resp = 8'h6C;
        issue(1'b0, 8'h22, 8'h00);
        repeat (30) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h55; req_wdata = 8'hAA;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        chk(rdata == 8'h6C, "R7 busy request ignored data", rdata, 8'h6C);
        repeat (80) @(negedge clk);
        chk(nfr == 2 && !busy, "R7 no extra frame", nfr, 2);
        chk(log_b[0][1] == 8'h22, "R7 first request kept", log_b[0][1], 8'h22);

        // Back-to-back: request in the done cycle (R10)
        clear_log();
        resp = 8'h99;
        prev = rdata;
        issue(1'b1, 8'h10, 8'h11);
        wait_done();
        chk(rdata == prev, "R9 write keeps rdata", rdata, prev);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h30; req_wdata = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R10 accepted in done cycle", busy, 1);
        wait_done();
        chk(rdata == 8'h99, "R10 second result", rdata, 8'h99);
        @(negedge clk);
        chk(nfr == 3, "R10 frame count", nfr, 3);
        check_frames(0, 1'b1, 8'h10, 8'h11, "R10 write bytes");
        check_frames(1, 1'b0, 8'h30, 8'h00, "R10 read bytes");

        finish_run();
    end

endmodule